// File: doc/BRIEF.md
# Priority-Pool Bus Arbiter

This block decides which of several bus masters may drive one shared slave. Every master carries a small programmable level, and the level places it in a pool. Between pools the higher level always wins. Within the lowest and the highest pool, requesters take turns in a rotating order. Within the middle levels, the requester with the largest master index wins. The block keeps one rotation pointer for the bottom pool and another for the top pool, so the two rotations do not disturb each other.

A grant lasts for one transfer. The arbiter looks at the requests again only when no grant is active or when the transfer-end strobe is high. When more than one master is requesting at that moment, the master granted most recently is left out, so no master holds the slave twice in a row unless it is the only one asking. The result is a one-hot grant vector and the matching binary index. Both are registered and appear one cycle after the decision.

Top module: `prio_pool_arbiter`

## Requirements
- R1: While reset is active and in the first cycle after it, `gnt_o` is all zeros and `gnt_idx_o` is 0. Both rotation pointers start at master 0, so with every master at level 0 and every master requesting, master 0 receives the first grant.
- R2: The arbiter decides only in a cycle where `gnt_o` is zero or `xfer_done_i` is 1. The decision appears on the outputs in the next cycle. In every other cycle the grant is held unchanged, whatever the requests do. A decision taken with no request pending clears the grant.
- R3: `gnt_o` is zero or one-hot. A set bit belongs to a master whose request was high in the deciding cycle. `gnt_idx_o` is the position of the set bit, and 0 when no bit is set.
- R4: The level of master m is `prio_i[2m+1:2m]`, from 0 to 3. Among the eligible requesters, only those at the largest level present can win.
- R5: When the winning level is 1 or 2, the eligible requester with the highest master index at that level is granted.
- R6: When the winning level is 0 or 3, that pool's pointer is used. The grant goes to the first eligible requester of that level found by scanning upward from the pointer and wrapping past N-1 to 0. The pointer is then set to the granted index plus one, modulo N. The pointer of the other pool is left as it is.
- R7: When two or more requests are high in a deciding cycle, the master granted last is not eligible, and this holds even after idle cycles. A master that is the only requester is granted again.
- R8: With all masters requesting continuously and a transfer ending every cycle, every master at level 0 gets an equal share of grants within one, provided no master sits above level 0. Every top-pool master waits for at most one grant of each other top-pool master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MST | Request line per master |
| prio_i | input | N_MST*LVL_W | Level per master, field m at bits [m*LVL_W +: LVL_W] |
| xfer_done_i | input | 1 | Last cycle of the current transfer |
| gnt_o | output | N_MST | One-hot grant, zero when the bus is idle |
| gnt_idx_o | output | IDX_W | Index of the granted master |

## Verification
The assertions assume that `xfer_done_i` matters only while a grant is active. They also assume that requests and levels are sampled only in deciding cycles, so the checks on holding, on back-to-back grants and on granting only requesters are all keyed to those cycles. The random stimulus changes requests, levels and the strobe freely in every cycle, including while a transfer is running and while the bus is idle. This shows that values arriving between decisions never reach the grant. The directed phases keep requests and levels fixed across several decisions, which is what the rotation order, the fixed-priority order and the fairness counts need.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        POOL_LOW,
        POOL_MID,
        POOL_TOP
    } pool_e;

    // Sort a level into its pool: the bottom and top levels rotate,
    // every level in between uses the fixed highest-index rule.
    function automatic pool_e pool_of(input int unsigned lvl, input int unsigned top_lvl);
        if (lvl == 0)
            return POOL_LOW;
        else if (lvl == top_lvl)
            return POOL_TOP;
        else
            return POOL_MID;
    endfunction

endpackage

// File: rtl/arb_level_scan.sv
module arb_level_scan #(
    parameter int N_MST = 4,
    parameter int LVL_W = 2
) (
    input  logic [N_MST-1:0]       elig_i,
    input  logic [N_MST*LVL_W-1:0] prio_i,
    output logic [LVL_W-1:0]       lvl_o,
    output logic [N_MST-1:0]       mask_o,
    output logic                   any_o
);
    localparam int N_LVL = 1 << LVL_W;

    logic [LVL_W-1:0] mst_lvl [N_MST];

    for (genvar m = 0; m < N_MST; m++) begin : g_field
        assign mst_lvl[m] = prio_i[m*LVL_W +: LVL_W];
    end

    always_comb begin
        lvl_o  = '0;
        mask_o = '0;
        any_o  = |elig_i;
        for (int l = 0; l < N_LVL; l++) begin
            for (int m = 0; m < N_MST; m++) begin
                if (elig_i[m] && (mst_lvl[m] == LVL_W'(l)))
                    lvl_o = LVL_W'(l);
            end
        end
        for (int m = 0; m < N_MST; m++)
            mask_o[m] = elig_i[m] && (mst_lvl[m] == lvl_o);
    end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N_MST = 4,
    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic [N_MST-1:0] mask_i,
    input  logic [IDX_W-1:0] ptr_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             hit_o
);
    always_comb begin
        idx_o = '0;
        hit_o = 1'b0;
        for (int k = 0; k < N_MST; k++) begin
            int j;
            j = int'(ptr_i) + k;
            if (j >= N_MST)
                j = j - N_MST;
            if (!hit_o && mask_i[j]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/arb_hi_pick.sv
module arb_hi_pick #(
    parameter int N_MST = 4,
    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic [N_MST-1:0] mask_i,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int m = 0; m < N_MST; m++) begin
            if (mask_i[m])
                idx_o = IDX_W'(m);
        end
    end
endmodule

// File: rtl/prio_pool_arbiter.sv
module prio_pool_arbiter
    import arb_pkg::*;
#(
    parameter int N_MST = 4,
    parameter int LVL_W = 2,
    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_MST-1:0]       req_i,
    input  logic [N_MST*LVL_W-1:0] prio_i,
    input  logic                   xfer_done_i,
    output logic [N_MST-1:0]       gnt_o,
    output logic [IDX_W-1:0]       gnt_idx_o
);
    localparam int unsigned TOP_LVL = (1 << LVL_W) - 1;

    typedef struct packed {
        logic [N_MST-1:0] gnt;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
        logic             last_vld;
        logic [IDX_W-1:0] ptr_lo;
        logic [IDX_W-1:0] ptr_hi;
    } arb_st_t;

    arb_st_t s_d, s_q;

    logic [N_MST-1:0] excl;
    logic [N_MST-1:0] elig;
    logic [N_MST-1:0] lvl_mask;
    logic [LVL_W-1:0] win_lvl;
    logic             any_elig;
    logic [IDX_W-1:0] lo_idx, hi_idx, fx_idx;
    logic             lo_hit, hi_hit;
    pool_e            win_pool;

    // Back-to-back exclusion, applied only when there is contention.
    always_comb begin
        excl = '0;
        if (($countones(req_i) > 1) && s_q.last_vld)
            excl[s_q.last] = 1'b1;
    end

    assign elig     = req_i & ~excl;
    assign win_pool = pool_of(int'(win_lvl), TOP_LVL);

    arb_level_scan #(.N_MST(N_MST), .LVL_W(LVL_W)) u_scan (
        .elig_i (elig),
        .prio_i (prio_i),
        .lvl_o  (win_lvl),
        .mask_o (lvl_mask),
        .any_o  (any_elig)
    );

    arb_rr_pick #(.N_MST(N_MST)) u_rr_lo (
        .mask_i (lvl_mask),
        .ptr_i  (s_q.ptr_lo),
        .idx_o  (lo_idx),
        .hit_o  (lo_hit)
    );

    arb_rr_pick #(.N_MST(N_MST)) u_rr_hi (
        .mask_i (lvl_mask),
        .ptr_i  (s_q.ptr_hi),
        .idx_o  (hi_idx),
        .hit_o  (hi_hit)
    );

    arb_hi_pick #(.N_MST(N_MST)) u_fixed (
        .mask_i (lvl_mask),
        .idx_o  (fx_idx)
    );

    always_comb begin
        logic             arb_now;
        logic [IDX_W-1:0] sel;
        logic [IDX_W-1:0] nxt;
        s_d     = s_q;
        arb_now = (s_q.gnt == '0) || xfer_done_i;
        sel     = fx_idx;
        if (win_pool == POOL_LOW && lo_hit)
            sel = lo_idx;
        else if (win_pool == POOL_TOP && hi_hit)
            sel = hi_idx;
        nxt = (sel == IDX_W'(N_MST - 1)) ? '0 : sel + 1'b1;
        if (arb_now) begin
            if (any_elig) begin
                s_d.gnt      = '0;
                s_d.gnt[sel] = 1'b1;
                s_d.idx      = sel;
                s_d.last     = sel;
                s_d.last_vld = 1'b1;
                if (win_pool == POOL_LOW)
                    s_d.ptr_lo = nxt;
                if (win_pool == POOL_TOP)
                    s_d.ptr_hi = nxt;
            end else begin
                s_d.gnt = '0;
                s_d.idx = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign gnt_o     = s_q.gnt;
    assign gnt_idx_o = s_q.idx;

endmodule

// File: rtl/prio_pool_arbiter_chk.sv
module prio_pool_arbiter_chk #(
    parameter int N_MST = 4,
    parameter int LVL_W = 2,
    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_MST-1:0]       req_i,
    input logic [N_MST*LVL_W-1:0] prio_i,
    input logic                   xfer_done_i,
    input logic [N_MST-1:0]       gnt_o,
    input logic [IDX_W-1:0]       gnt_idx_o
);
    logic deciding;
    assign deciding = (gnt_o == '0) || xfer_done_i;

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (gnt_o == '0) && (gnt_idx_o == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !deciding |=> (gnt_o == $past(gnt_o)) && (gnt_idx_o == $past(gnt_idx_o)));

    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    p_idx_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0) |-> gnt_o[gnt_idx_o]);

    p_idx_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0) |-> (gnt_idx_o == '0));

    p_only_requester_r3: assert property (@(posedge clk) disable iff (!rst_n)
        deciding |=> ((gnt_o & ~$past(req_i)) == '0));

    p_no_back_to_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o != '0) && xfer_done_i && ($countones(req_i) > 1)) |=> (gnt_o != $past(gnt_o)));

    p_sole_regrant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o != '0) && xfer_done_i && (req_i == gnt_o)) |=> $stable(gnt_o));

endmodule

bind prio_pool_arbiter prio_pool_arbiter_chk #(.N_MST(N_MST), .LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .prio_i      (prio_i),
    .xfer_done_i (xfer_done_i),
    .gnt_o       (gnt_o),
    .gnt_idx_o   (gnt_idx_o)
);

// File: tb/test_prio_pool_arbiter.sv
module test_prio_pool_arbiter;
    localparam int N  = 4;
    localparam int LW = 2;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N*LW-1:0] prio = '0;
    logic          done = 1'b0;
    logic [N-1:0]  gnt;
    logic [IW-1:0] idx;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int cnt [N];

    logic [N-1:0]  e_gnt = '0;
    logic [IW-1:0] e_idx = '0;
    int m_last = 0;
    bit m_lv = 0;
    int m_plo = 0;
    int m_phi = 0;
    bit new_grant = 0;

    always #2 clk = ~clk;

    prio_pool_arbiter #(.N_MST(N), .LVL_W(LW)) i_prio_pool_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .prio_i      (prio),
        .xfer_done_i (done),
        .gnt_o       (gnt),
        .gnt_idx_o   (idx)
    );

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic check_eq(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int lvl(input int m);
        return int'(prio[m*LW +: LW]);
    endfunction

    // Requirement-level model of one decision, using current inputs.
    task automatic model_arb();
        logic [N-1:0] el;
        int best;
        int win;
        new_grant = 0;
        if (e_gnt != '0 && !done) return;
        el = req;
        if ($countones(req) > 1 && m_lv) el[m_last] = 1'b0;
        if (el == '0) begin
            e_gnt = '0;
            e_idx = '0;
            return;
        end
        best = -1;
        for (int m = 0; m < N; m++)
            if (el[m] && lvl(m) > best) best = lvl(m);
        win = -1;
        if (best == 1 || best == 2) begin
            for (int m = 0; m < N; m++)
                if (el[m] && lvl(m) == best) win = m;
        end else begin
            int p;
            p = (best == 3) ? m_phi : m_plo;
            for (int k = 0; k < N; k++) begin
                int j;
                j = (p + k) % N;
                if (win < 0 && el[j] && lvl(j) == best) win = j;
            end
            if (best == 3) m_phi = (win + 1) % N;
            else           m_plo = (win + 1) % N;
        end
        e_gnt = '0;
        e_gnt[win] = 1'b1;
        e_idx = IW'(win);
        m_last = win;
        m_lv = 1;
        new_grant = 1;
    endtask

    // Called at a falling edge: drive, predict, then compare one cycle later.
    task automatic step(input logic [N-1:0] r, input logic [N*LW-1:0] p, input logic d);
        req  = r;
        prio = p;
        done = d;
        model_arb();
        @(negedge clk);
        check_eq(int'(gnt), int'(e_gnt), "R2 R4 R5 R6 R7 model grant");
        check_eq(int'(idx), int'(e_idx), "R3 model index");
        if (new_grant && gnt != '0) cnt[idx]++;
    endtask

    task automatic clear_cnt();
        for (int m = 0; m < N; m++) cnt[m] = 0;
    endtask

    initial begin
        repeat (20000 * 10) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [N-1:0] held;
        clear_cnt();
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        check_eq(int'(gnt), 0, "R1 grant during reset");
        check_eq(int'(idx), 0, "R1 index during reset");
        rst_n = 1'b1;

        // Bottom pool rotation from reset: 0,1,2,3,0
        for (int k = 0; k < 5; k++) begin
            step(4'hF, 8'h00, 1'b1);
            check_eq(int'(idx), k % N, (k == 0) ? "R1 first grant" : "R6 rotation order");
        end

        // Middle levels: m1,m2 at level 2, m0,m3 at level 1; last granted is 0
        step(4'hF, 8'h69, 1'b1);
        check_eq(int'(idx), 2, "R5 highest index at level 2");
        step(4'hF, 8'h69, 1'b1);
        check_eq(int'(idx), 1, "R5 R7 next at level 2 after exclusion");
        step(4'hF, 8'h69, 1'b1);
        check_eq(int'(idx), 2, "R5 back to index 2");

        // Top level beats all others
        step(4'hF, 8'hC0, 1'b1);
        check_eq(int'(idx), 3, "R4 top level wins");
        step(4'hF, 8'hC0, 1'b1);
        check_eq(int'(idx == 3), 0, "R7 no repeat under contention");

        // Hold during a transfer
        held = gnt;
        for (int k = 0; k < 4; k++) begin
            step(N'($urandom), 8'($urandom), 1'b0);
            check_eq(int'(gnt), int'(held), "R2 grant held mid-transfer");
        end

        // Sole requester keeps winning
        for (int k = 0; k < 3; k++) begin
            step(4'b0010, 8'h00, 1'b1);
            check_eq(int'(idx), 1, "R7 sole requester regranted");
        end

        // Idle
        step(4'b0000, 8'h00, 1'b1);
        check_eq(int'(gnt), 0, "R2 no request clears grant");
        step(4'b0000, 8'hFF, 1'b0);
        check_eq(int'(gnt), 0, "R2 stays idle");

        // Fairness in bottom pool
        clear_cnt();
        for (int k = 0; k < 40; k++) step(4'hF, 8'h00, 1'b1);
        for (int m = 0; m < N; m++)
            check_eq(int'(cnt[m] >= 9 && cnt[m] <= 11), 1, "R8 bottom pool share");

        // Top pool latency: m0 and m2 at level 3
        clear_cnt();
        for (int k = 0; k < 40; k++) step(4'hF, 8'h33, 1'b1);
        check_eq(int'(cnt[0] >= 19 && cnt[0] <= 21), 1, "R8 top pool share m0");
        check_eq(int'(cnt[2] >= 19 && cnt[2] <= 21), 1, "R8 top pool share m2");

        // Random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] r;
            r = N'($urandom);
            if (($urandom % 8) == 0) r = '0;
            step(r, 8'($urandom), (($urandom % 3) != 0));
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule